// File: doc/BRIEF.md
# Multidrop Serial Receive Channel with Per-Character Status Queue

This block is one asynchronous receive channel. It watches a serial line through a 16x oversampling enable and finds start bits, checking each one at mid-bit. It then assembles a character of eight data bits, an optional ninth bit and a stop bit. Each finished character goes into a three-entry queue together with a three-bit status word: the ninth-bit slot, a framing-error flag and a break flag. A host reads the head entry through a single pop strobe, and data and status leave together.

The ninth bit has one of two uses. As parity, the slot records a parity error. In multidrop (address wake-up) mode the slot records the raw address/data bit, with no parity check. While the receiver is disabled, ordinary characters are dropped. In multidrop mode, address characters are still queued so that a station can wake on its address. A flow-control output tells the remote sender to stop while the queue is full. A character that arrives at a full queue is lost and raises a sticky overrun flag.

Top module: `mdrx_channel`

## Requirements
- R1: The line idles high. A frame is a low start bit, then eight data bits least significant first, then an optional ninth bit (`ninth_en`=1), then a stop bit. Each accepted frame adds one queue entry whose `rd_data` equals the data bits.
- R2: A falling edge starts a frame only if the line is still low on the eighth sample tick after the edge. A low pulse shorter than that loads nothing.
- R3: With `ninth_en`=1 and `multidrop`=0, `rd_slot9` is 1 when the count of ones over the data and ninth bits is odd and `parity_odd`=0, or is even and `parity_odd`=1. Otherwise it is 0. It is 0 whenever `ninth_en`=0.
- R4: With `ninth_en`=1 and `multidrop`=1, `rd_slot9` holds the received ninth bit unchanged.
- R5: `rd_frame_err` is 1 exactly when the stop bit is sampled low.
- R6: A frame whose data, ninth bit and stop bit are all low is a break. It loads one entry with data 0, `rd_break`=1 and `rd_frame_err`=1. No further entry is loaded until the line has returned high and a new start bit arrives.
- R7: The queue holds three entries and returns them in arrival order. `fifo_full` is 1 while three entries are held.
- R8: A frame that completes while the queue is full, with no pop in the same cycle, is discarded and sets `overrun`. `overrun` then stays set until reset, and the stored entries are unchanged.
- R9: `rx_ready` is 1 while the queue is not empty. It falls once the last entry has been popped. A pop of an empty queue has no effect.
- R10: `rts_out` is 0 while `fifo_full`=1 and `flow_en`=1. In every other case it is 1.
- R11: With `rx_enable`=0, frames are discarded. The exception is multidrop mode (`ninth_en`=1, `multidrop`=1), where frames whose ninth bit is 1 are still loaded.
- R12: A synchronous active-high `rst` empties the queue, clears `overrun` and returns the receiver to hunting for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input |
| rx_enable | input | 1 | Receiver enable |
| ninth_en | input | 1 | A ninth bit follows the data bits |
| multidrop | input | 1 | Ninth bit is address/data rather than parity |
| parity_odd | input | 1 | Odd parity when 1, even when 0 |
| flow_en | input | 1 | Lets `rts_out` follow the queue state |
| pop | input | 1 | Removes the head entry |
| rd_data | output | 8 | Head entry data |
| rd_slot9 | output | 1 | Head entry parity error or address bit |
| rd_frame_err | output | 1 | Head entry framing error |
| rd_break | output | 1 | Head entry break flag |
| rx_ready | output | 1 | Queue not empty |
| fifo_full | output | 1 | Queue holds three entries |
| overrun | output | 1 | Sticky lost-character flag |
| rts_out | output | 1 | Clear-to-send indication toward the remote sender |

## Verification
The bench sweeps many data values through all four ninth-bit settings and computes the expected slot bit by counting ones. A design that inverted the parity sense, or that checked parity in multidrop mode, fails there. It sends a start glitch shorter than mid-bit and a long break. A receiver that did not check the start bit at mid-bit would load garbage from the glitch. One that re-armed while the line was still low would load a run of zero characters for the break. It also fills the queue and sends one more frame, pops an empty queue and disables the receiver. Those steps expose lost ordering, a non-sticky or misplaced overrun, a pop that corrupts pointers, or address frames dropped while the receiver is off.

// File: rtl/mdrx_pkg.sv
package mdrx_pkg;
  localparam int MAX_DW = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_NINTH, S_STOP, S_HOLD
  } rx_state_e;

  typedef struct packed {
    logic slot9;
    logic frame_err;
    logic brk;
  } rx_stat_t;

  // parity fault: total ones over data and ninth bit disagree with the chosen sense
  function automatic logic parity_fault(input logic [MAX_DW-1:0] d, input logic b9,
                                        input logic odd);
    return (^d) ^ b9 ^ odd;
  endfunction

  function automatic logic is_break(input logic [MAX_DW-1:0] d, input logic b9,
                                    input logic stop);
    return (d == '0) && !b9 && !stop;
  endfunction
endpackage

// File: rtl/mdrx_sampler.sv
module mdrx_sampler
  import mdrx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OSR       = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 rxd,
  input  logic                 ninth_en,
  output logic                 done,
  output logic [DATA_BITS-1:0] data,
  output logic                 b9,
  output logic                 stop_bit,
  output logic                 start_reject
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DATA_BITS + 1);
  localparam logic [CW-1:0] MID     = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST    = CW'(OSR - 1);
  localparam logic [BW-1:0] LASTBIT = BW'(DATA_BITS - 1);

  rx_state_e       st;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bitn;

  assign start_reject = (st == S_START) && tick && (cnt == MID) && rxd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      data     <= '0;
      b9       <= 1'b0;
      stop_bit <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (tick && !rxd) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: if (tick) begin
          if (cnt == MID) begin
            if (rxd) st <= S_IDLE;
            else begin
              st   <= S_DATA;
              cnt  <= '0;
              bitn <= '0;
              b9   <= 1'b0;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: if (tick) begin
          if (cnt == LAST) begin
            data <= {rxd, data[DATA_BITS-1:1]};
            cnt  <= '0;
            if (bitn == LASTBIT) st <= ninth_en ? S_NINTH : S_STOP;
            else bitn <= bitn + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_NINTH: if (tick) begin
          if (cnt == LAST) begin
            b9  <= rxd;
            cnt <= '0;
            st  <= S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: if (tick) begin
          if (cnt == LAST) begin
            stop_bit <= rxd;
            done     <= 1'b1;
            cnt      <= '0;
            st       <= rxd ? S_IDLE : S_HOLD;
          end else cnt <= cnt + 1'b1;
        end
        S_HOLD: if (tick && rxd) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mdrx_fifo.sv
module mdrx_fifo #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             overflow
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));
  assign pop_ok   = pop && !empty;
  assign push_ok  = push && (!full || pop_ok);
  assign overflow = push && full && !pop_ok;
  assign rdata    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= next_ptr(wp);
      if (pop_ok)  rp <= next_ptr(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/mdrx_channel.sv
module mdrx_channel
  import mdrx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OSR         = 16,
  parameter int DEPTH       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_tick,
  input  logic                 rx_line,
  input  logic                 rx_enable,
  input  logic                 ninth_en,
  input  logic                 multidrop,
  input  logic                 parity_odd,
  input  logic                 flow_en,
  input  logic                 pop,
  output logic [DATA_BITS-1:0] rd_data,
  output logic                 rd_slot9,
  output logic                 rd_frame_err,
  output logic                 rd_break,
  output logic                 rx_ready,
  output logic                 fifo_full,
  output logic                 overrun,
  output logic                 rts_out
);
  localparam int SW = $bits(rx_stat_t);
  localparam int EW = DATA_BITS + SW;

  // input synchronizer, stage count chosen by parameter
  logic [SYNC_STAGES-1:0] sync_q;
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) sync_q[0] <= rst ? 1'b1 : rx_line;
      end else begin : g_next
        always_ff @(posedge clk) sync_q[g] <= rst ? 1'b1 : sync_q[g-1];
      end
    end
  endgenerate
  logic rxd;
  assign rxd = sync_q[SYNC_STAGES-1];

  // named internal events
  logic                 char_done, char_b9, char_stop, start_reject;
  logic [DATA_BITS-1:0] char_data;
  logic                 accept, push_req, push_ok, pop_ok, overflow_evt, q_empty;
  rx_stat_t             new_stat, head_stat;
  logic [EW-1:0]        head_word;

  mdrx_sampler #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_samp (
    .clk(clk), .rst(rst), .tick(sample_tick), .rxd(rxd), .ninth_en(ninth_en),
    .done(char_done), .data(char_data), .b9(char_b9), .stop_bit(char_stop),
    .start_reject(start_reject)
  );

  always_comb begin
    new_stat.slot9     = ninth_en &&
                         (multidrop ? char_b9
                                    : parity_fault(MAX_DW'(char_data), char_b9, parity_odd));
    new_stat.frame_err = !char_stop;
    new_stat.brk       = is_break(MAX_DW'(char_data), char_b9 && ninth_en, char_stop);
  end

  assign accept   = rx_enable || (ninth_en && multidrop && char_b9);
  assign push_req = char_done && accept;

  mdrx_fifo #(.WIDTH(EW), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst(rst), .push(push_req), .pop(pop), .wdata({new_stat, char_data}),
    .rdata(head_word), .empty(q_empty), .full(fifo_full), .push_ok(push_ok),
    .pop_ok(pop_ok), .overflow(overflow_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) overrun <= 1'b0;
    else if (overflow_evt) overrun <= 1'b1;
  end

  assign head_stat    = head_word[EW-1:DATA_BITS];
  assign rd_data      = head_word[DATA_BITS-1:0];
  assign rd_slot9     = head_stat.slot9;
  assign rd_frame_err = head_stat.frame_err;
  assign rd_break     = head_stat.brk;
  assign rx_ready     = !q_empty;
  assign rts_out      = !(flow_en && fifo_full);
endmodule

// File: rtl/mdrx_channel_chk.sv
module mdrx_channel_chk #(
  parameter int DEPTH = 3
) (
  input logic clk,
  input logic rst,
  input logic push_ok,
  input logic pop_ok,
  input logic overflow_evt,
  input logic char_done,
  input logic start_reject,
  input logic rx_ready,
  input logic fifo_full,
  input logic overrun,
  input logic rts_out,
  input logic flow_en
);
  int level;
  always_ff @(posedge clk) begin
    if (rst) level <= 0;
    else level <= level + int'(push_ok) - int'(pop_ok);
  end

  p_ready_level_r9: assert property (@(posedge clk) disable iff (rst)
    rx_ready == (level != 0));
  p_full_level_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_full == (level == DEPTH));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    level <= DEPTH);
  p_overrun_when_full_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(fifo_full));
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  p_drop_keeps_level_r8: assert property (@(posedge clk) disable iff (rst)
    overflow_evt |-> !push_ok);
  p_rts_stop_r10: assert property (@(posedge clk) disable iff (rst)
    (flow_en && level == DEPTH) |-> !rts_out);
  p_rts_go_r10: assert property (@(posedge clk) disable iff (rst)
    (level != DEPTH) |-> rts_out);
  p_reject_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    start_reject |=> !char_done);
endmodule

bind mdrx_channel mdrx_channel_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .push_ok(push_ok), .pop_ok(pop_ok),
  .overflow_evt(overflow_evt), .char_done(char_done), .start_reject(start_reject),
  .rx_ready(rx_ready), .fifo_full(fifo_full), .overrun(overrun), .rts_out(rts_out),
  .flow_en(flow_en)
);

// File: tb/mdrx_channel_bench.sv
module mdrx_channel_bench;
  localparam int BIT = 32;  // cycles per bit: one tick every 2 cycles, 16 ticks

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic rx_line = 1'b1;
  logic rx_enable = 1'b1, ninth_en = 1'b0, multidrop = 1'b0, parity_odd = 1'b0;
  logic flow_en = 1'b1, pop = 1'b0;
  logic [7:0] rd_data;
  logic rd_slot9, rd_frame_err, rd_break, rx_ready, fifo_full, overrun, rts_out;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  mdrx_channel u_mdrx_channel (
    .clk(clk), .rst(rst), .sample_tick(tick), .rx_line(rx_line), .rx_enable(rx_enable),
    .ninth_en(ninth_en), .multidrop(multidrop), .parity_odd(parity_odd),
    .flow_en(flow_en), .pop(pop), .rd_data(rd_data), .rd_slot9(rd_slot9),
    .rd_frame_err(rd_frame_err), .rd_break(rd_break), .rx_ready(rx_ready),
    .fifo_full(fifo_full), .overrun(overrun), .rts_out(rts_out)
  );

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic stop);
    rx_line = 1'b0; hold(BIT);
    for (int i = 0; i < 8; i++) begin rx_line = d[i]; hold(BIT); end
    if (ninth_en) begin rx_line = b9; hold(BIT); end
    rx_line = stop; hold(BIT);
    rx_line = 1'b1; hold(2 * BIT);
  endtask

  task automatic pop_expect(input string req, input logic [7:0] d, input logic s9,
                            input logic fe, input logic br);
    check(req, "ready", rx_ready, 1);
    check(req, "data", rd_data, d);
    check(req, "slot9", rd_slot9, s9);
    check(req, "frame_err", rd_frame_err, fe);
    check(req, "break", rd_break, br);
    pop = 1'b1; hold(1); pop = 1'b0;
  endtask

  function automatic logic exp_slot(input logic [7:0] d, input logic b9);
    int ones = 0;
    if (!ninth_en) return 1'b0;
    if (multidrop) return b9;
    for (int i = 0; i < 8; i++) ones += int'(d[i]);
    ones += int'(b9);
    return parity_odd ? (ones % 2 == 0) : (ones % 2 == 1);
  endfunction

  task automatic do_reset;
    rst = 1'b1; hold(3); rst = 1'b0; hold(2);
  endtask

  initial begin
    hold(4);
    do_reset;
    check("R12", "ready after reset", rx_ready, 0);
    check("R12", "full after reset", fifo_full, 0);
    check("R12", "overrun after reset", overrun, 0);
    check("R10", "rts after reset", rts_out, 1);

    // R1 R3 R4 R5: sweep data through four ninth-bit settings
    for (int m = 0; m < 4; m++) begin
      ninth_en = (m != 0); multidrop = (m == 3); parity_odd = (m == 2);
      for (int k = 0; k < 24; k++) begin
        logic [7:0] d;
        logic b9, st;
        d  = 8'(k * 37 + 1);
        b9 = 1'(k ^ (k >> 2));
        st = !(k % 7 == 5);
        send(d, b9, st);
        pop_expect(m == 3 ? "R4" : (m == 0 ? "R1" : "R3"), d, exp_slot(d, b9), !st, 1'b0);
        check("R5", "empty after pop", rx_ready, 0);
      end
    end
    ninth_en = 1'b0; multidrop = 1'b0; parity_odd = 1'b0;

    // R2: short low glitch
    rx_line = 1'b0; hold(12); rx_line = 1'b1; hold(3 * BIT);
    check("R2", "glitch not loaded", rx_ready, 0);
    send(8'hC3, 1'b0, 1'b1);
    pop_expect("R2", 8'hC3, 1'b0, 1'b0, 1'b0);

    // R6: long break loads one entry
    rx_line = 1'b0; hold(14 * BIT); rx_line = 1'b1; hold(2 * BIT);
    pop_expect("R6", 8'h00, 1'b0, 1'b1, 1'b1);
    check("R6", "single break entry", rx_ready, 0);
    send(8'h5A, 1'b0, 1'b1);
    pop_expect("R6", 8'h5A, 1'b0, 1'b0, 1'b0);

    // R7 R8 R10: fill, overrun, drain
    flow_en = 1'b1;
    send(8'h11, 1'b0, 1'b1); send(8'h22, 1'b0, 1'b1);
    check("R7", "not full at two", fifo_full, 0);
    check("R10", "rts at two", rts_out, 1);
    send(8'h33, 1'b0, 1'b1);
    check("R7", "full at three", fifo_full, 1);
    check("R10", "rts low when full", rts_out, 0);
    check("R8", "no overrun yet", overrun, 0);
    send(8'h44, 1'b0, 1'b1);
    check("R8", "overrun set", overrun, 1);
    pop_expect("R7", 8'h11, 1'b0, 1'b0, 1'b0);
    check("R10", "rts back", rts_out, 1);
    pop_expect("R8", 8'h22, 1'b0, 1'b0, 1'b0);
    pop_expect("R8", 8'h33, 1'b0, 1'b0, 1'b0);
    check("R9", "ready falls", rx_ready, 0);
    pop = 1'b1; hold(1); pop = 1'b0; hold(1);
    check("R9", "empty pop ignored", rx_ready, 0);
    send(8'h55, 1'b0, 1'b1);
    pop_expect("R9", 8'h55, 1'b0, 1'b0, 1'b0);
    check("R8", "overrun sticky", overrun, 1);

    // R10 with flow control off
    flow_en = 1'b0;
    send(8'h01, 1'b0, 1'b1); send(8'h02, 1'b0, 1'b1); send(8'h03, 1'b0, 1'b1);
    check("R10", "full flow off", fifo_full, 1);
    check("R10", "rts high flow off", rts_out, 1);

    // R12: reset empties and clears
    do_reset;
    check("R12", "reset empties", rx_ready, 0);
    check("R12", "reset clears full", fifo_full, 0);
    check("R12", "reset clears overrun", overrun, 0);
    flow_en = 1'b1;

    // R11: receiver disabled
    rx_enable = 1'b0;
    send(8'hA5, 1'b0, 1'b1);
    check("R11", "disabled plain dropped", rx_ready, 0);
    ninth_en = 1'b1; multidrop = 1'b1;
    send(8'h12, 1'b0, 1'b1);
    check("R11", "disabled data frame dropped", rx_ready, 0);
    send(8'h34, 1'b1, 1'b1);
    pop_expect("R11", 8'h34, 1'b1, 1'b0, 1'b0);
    rx_enable = 1'b1;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule